// File: doc/BRIEF.md
# Timer Clock Prescale Control Register

This block is an 8-bit control register, written and read over a simple register bus, that sets up the clock path of a PWM timer and runs that timer's counting logic. The register holds a PLL enable, a two-bit PLL divide selector, a timer clock-source select, an instruction clock-mode select and a three-bit prescale field. Guard logic decides which of the clock-select bits a write may change, based on the PLL enable and on whether the timer is running.

The prescale field sets how many input clocks make up one timer count, from 1 to 8. A prescaler turns that field into count-enable pulses for a counter (12 bits by default). While the timer runs, a newly written prescale value waits as a pending value and becomes the active divide factor only on the edge where the counter wraps to zero. Readback always shows the most recently written value. While the timer is stopped, a written value becomes active at once. The selected clock outputs drive clock multiplexers outside this block.

Top module: `tpc_timer_ctrl`

## Requirements
- R1: A write stores wr_data[7] as the PLL enable and wr_data[6:5] as the PLL divide select; rd_data returns them in the same bit positions on the following cycle.
- R2: The timer clock-source bit (bit 4) takes the written value only when the PLL enable was 1 before the write and run is low. Otherwise the write leaves the bit unchanged.
- R3: When the PLL enable was 0 before a write, the instruction clock-mode bit (bit 3) becomes 0 whatever value was written. Otherwise it takes the written value.
- R4: Whenever the PLL enable is 0, bits 4 and 3 both read 0. A write that clears bit 7 also clears both of them.
- R5: While run is high, tick pulses once every P+1 clocks, where P is the active prescale value (0 gives divide-by-1, 7 gives divide-by-8).
- R6: The counter advances by one on each tick. ovf is high for the single cycle in which a tick finds the counter at its maximum value, and the counter is 0 after that edge.
- R7: While run is high, ps_active changes only on the ovf edge. On that edge it takes the last prescale value written before that edge.
- R8: rd_data[2:0] returns the most recently written prescale value, even when that value is not yet active.
- R9: While run is low, tick stays low, the counter holds its value, and a prescale write makes ps_active equal to the written value on the next cycle.
- R10: After reset, rd_data, ps_active and count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| run | input | 1 | Timer run enable |
| rd_data | output | 8 | Register readback |
| pll_en | output | 1 | PLL enable |
| pll_div | output | 2 | PLL divide select |
| tsrc_fast | output | 1 | Timer clock from PLL output |
| iclk_fast | output | 1 | Instruction clock from PLL-derived source |
| ps_active | output | 3 | Prescale value currently in use |
| tick | output | 1 | Counter increment pulse |
| count | output | CNT_W | Timer counter value |
| ovf | output | 1 | Counter wrap pulse |

## Verification
The bench builds the block with CNT_W set to 5. A counter cycle then lasts at most 256 clocks, so a single run covers many wraps. That makes it practical to queue several prescale writes inside one counter cycle and to watch the last one take effect on the wrap edge. It also lets the bench step through different divide factors, including 1 and 8, across successive cycles. The prescale width keeps its default of 3, so every divide factor from 1 to 8 stays in reach.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int PLL_BIT  = 7;
  localparam int DIV_HI   = 6;
  localparam int DIV_LO   = 5;
  localparam int TSRC_BIT = 4;
  localparam int ICLK_BIT = 3;

  // clock-source select: write allowed only with PLL on and timer idle
  function automatic logic guard_tsrc(input logic pll_old, input logic run,
                                      input logic cur, input logic req);
    return (pll_old && !run) ? req : cur;
  endfunction

  // clock-mode select: forced low while the PLL was off
  function automatic logic guard_iclk(input logic pll_old, input logic req);
    return pll_old & req;
  endfunction

  function automatic int div_factor(input int ps);
    return ps + 1;
  endfunction
endpackage

// File: rtl/tpc_regs.sv
module tpc_regs #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            run,
  input  logic            ovf,
  output logic            pll_en,
  output logic [1:0]      pll_div,
  output logic            tsrc_fast,
  output logic            iclk_fast,
  output logic [PS_W-1:0] ps_wr,
  output logic [PS_W-1:0] ps_act
);
  import tpc_pkg::*;

  logic tsrc_n, iclk_n;
  logic load_now;   // stopped write: immediate
  logic load_pend;  // overflow or idle: take pending value

  always_comb begin
    tsrc_n = guard_tsrc(pll_en, run, tsrc_fast, wr_data[TSRC_BIT]);
    iclk_n = guard_iclk(pll_en, wr_data[ICLK_BIT]);
    if (!wr_data[PLL_BIT]) begin
      tsrc_n = 1'b0;
      iclk_n = 1'b0;
    end
  end

  assign load_now  = wr_en && !run;
  assign load_pend = !run || ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_en    <= 1'b0;
      pll_div   <= '0;
      tsrc_fast <= 1'b0;
      iclk_fast <= 1'b0;
      ps_wr     <= '0;
      ps_act    <= '0;
    end else begin
      if (wr_en) begin
        pll_en    <= wr_data[PLL_BIT];
        pll_div   <= wr_data[DIV_HI:DIV_LO];
        tsrc_fast <= tsrc_n;
        iclk_fast <= iclk_n;
        ps_wr     <= wr_data[PS_W-1:0];
      end
      if (load_now)       ps_act <= wr_data[PS_W-1:0];
      else if (load_pend) ps_act <= ps_wr;
    end
  end

  p_tsrc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[PLL_BIT] && (!pll_en || run)) |=> $stable(tsrc_fast));
  p_iclk_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pll_en) |=> !iclk_fast);
  p_pll_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> (!tsrc_fast && !iclk_fast));
  p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ovf) |=> $stable(ps_act));
  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ps_wr == $past(wr_data[PS_W-1:0]));
endmodule

// File: rtl/tpc_prescaler.sv
module tpc_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps_act,
  output logic            tick
);
  logic [PS_W-1:0] pre_cnt;

  assign tick = run && (pre_cnt == ps_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_cnt <= '0;
    else if (!run || tick)   pre_cnt <= '0;
    else                     pre_cnt <= pre_cnt + 1'b1;
  end

  p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_cnt <= ps_act));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/tpc_counter.sv
module tpc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  assign ovf = tick && (count == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  p_ovf_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == '0));
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf) |=> (count == $past(count) + 1'b1));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/tpc_timer_ctrl.sv
module tpc_timer_ctrl #(
  parameter int CNT_W = 12,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             run,
  output logic [7:0]       rd_data,
  output logic             pll_en,
  output logic [1:0]       pll_div,
  output logic             tsrc_fast,
  output logic             iclk_fast,
  output logic [PS_W-1:0]  ps_active,
  output logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [PS_W-1:0] ps_wr;

  tpc_regs #(.PS_W(PS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .run(run),
    .ovf(ovf), .pll_en(pll_en), .pll_div(pll_div), .tsrc_fast(tsrc_fast),
    .iclk_fast(iclk_fast), .ps_wr(ps_wr), .ps_act(ps_active)
  );

  tpc_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .ps_act(ps_active), .tick(tick)
  );

  tpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .ovf(ovf)
  );

  assign rd_data = {pll_en, pll_div, tsrc_fast, iclk_fast, ps_wr};

  p_rd_pll_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[7:5] == $past(wr_data[7:5])));
endmodule

// File: tb/tpc_timer_ctrl_tb.sv
module tpc_timer_ctrl_tb;
  localparam int CW   = 5;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic run = 1'b0;
  logic [7:0] rd_data;
  logic pll_en, tsrc_fast, iclk_fast, tick, ovf;
  logic [1:0] pll_div;
  logic [2:0] ps_active;
  logic [CW-1:0] count;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_pll = 0, m_div = 0, m_fsel = 0, m_fmode = 0, m_ps = 0, m_act = 0;
  int m_pre = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  tpc_timer_ctrl #(.CNT_W(CW), .PS_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .run(run),
    .rd_data(rd_data), .pll_en(pll_en), .pll_div(pll_div),
    .tsrc_fast(tsrc_fast), .iclk_fast(iclk_fast), .ps_active(ps_active),
    .tick(tick), .count(count), .ovf(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d, input logic r);
    int e_tick, e_ovf, fs, fm, old_pll;
    @(negedge clk);
    wr_en = we; wr_data = d; run = r;
    #1;
    e_tick = (r && m_pre == m_act) ? 1 : 0;
    e_ovf  = (e_tick == 1 && m_cnt == MAXC) ? 1 : 0;
    chk("R1 pll", int'(rd_data[7:5]), m_pll * 4 + m_div);
    chk("R2 tsrc", int'(rd_data[4]), m_fsel);
    chk("R3 iclk", int'(rd_data[3]), m_fmode);
    chk("R8 ps readback", int'(rd_data[2:0]), m_ps);
    chk("R7 ps_active", int'(ps_active), m_act);
    chk("R5 tick", int'(tick), e_tick);
    chk("R6 count", int'(count), m_cnt);
    chk("R6 ovf", int'(ovf), e_ovf);
    @(posedge clk);
    old_pll = m_pll;
    if (e_tick == 1) begin
      m_cnt = (m_cnt + 1) % (MAXC + 1);
      m_pre = 0;
    end else if (!r) m_pre = 0;
    else m_pre = m_pre + 1;
    if (we && !r) m_act = int'(d[2:0]);
    else if (!r || e_ovf == 1) m_act = m_ps;
    if (we) begin
      fs = (old_pll == 1 && !r) ? int'(d[4]) : m_fsel;
      fm = (old_pll == 1) ? int'(d[3]) : 0;
      m_pll = int'(d[7]); m_div = int'(d[6:5]); m_ps = int'(d[2:0]);
      if (m_pll == 0) begin fs = 0; fm = 0; end
      m_fsel = fs; m_fmode = fm;
    end
  endtask

  task automatic idle(input int n, input logic r);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, r);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset state
    chk("R10 rd_data", int'(rd_data), 0);
    chk("R10 ps_active", int'(ps_active), 0);
    chk("R10 count", int'(count), 0);
    // PLL off: tsrc ignored, iclk forced 0
    step(1'b1, 8'h1F, 1'b0);
    idle(2, 1'b0);
    chk("R3 forced", int'(iclk_fast), 0);
    chk("R9 immediate", int'(ps_active), 7);
    // enable PLL, then set selects while stopped
    step(1'b1, 8'hC0, 1'b0);
    step(1'b1, 8'hD9, 1'b0);
    idle(1, 1'b0);
    chk("R2 set", int'(tsrc_fast), 1);
    chk("R1 div", int'(pll_div), 2);
    // run at divide-by-2
    idle(200, 1'b1);
    // several writes within one counter cycle, last wins; tsrc write ignored
    step(1'b1, 8'hC3, 1'b1);
    idle(10, 1'b1);
    step(1'b1, 8'hC5, 1'b1);
    idle(400, 1'b1);
    // divide-by-8 and divide-by-1 while running
    step(1'b1, 8'hCF, 1'b1);
    idle(600, 1'b1);
    step(1'b1, 8'hC8, 1'b1);
    idle(300, 1'b1);
    // stop: counter holds, prescale immediate
    idle(5, 1'b0);
    step(1'b1, 8'hCE, 1'b0);
    idle(1, 1'b0);
    chk("R9 stopped write", int'(ps_active), 6);
    // clearing PLL clears both selects
    step(1'b1, 8'h1B, 1'b0);
    idle(1, 1'b0);
    chk("R4 tsrc", int'(tsrc_fast), 0);
    chk("R4 iclk", int'(iclk_fast), 0);
    idle(300, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule